// File: doc/BRIEF.md
# Host Bus Read-Drive Enable with Phase Cutoff

This block makes the active-low output enable that tells an external bus bridge to put read data on a slow (about 1 MHz) host bus. It runs on a fast logic clock (54 MHz in the target system). Its inputs are the bus phase signal (phi0) after it has passed through a synchronizer, and the read-enable outputs of every emulated card. The synchronizer adds about six logic clocks of delay. Without help, the bridge would therefore keep driving the bus for roughly 100 ns after the real end of the phase, and that drive would collide with the next bus phase.

The enable stays a purely combinational function of its inputs, because a registered enable would stretch the drive by one more cycle. A phase counter tracks how many logic clocks have passed since the last change of the synchronized phi0. While phi0 is high and the counter has reached a cutoff position, the enable is forced off even if a card requests a read.

The cutoff position is HALF_CYCLE − SYNC_DELAY + DRIVE_MARGIN. With the defaults this is 26 − 6 + 2 = 22, which is two clocks after the estimated real fall of phi0 at position 20.

Top module: `bus_drive_gate`

## Requirements
- R1: `bus_oe_n_o` is 0 when out of reset, DRIVE_ENABLE is 1, at least one bit of `card_rd_en_i` is 1, and the cutoff is not active.
- R2: `bus_oe_n_o` is 1 whenever every bit of `card_rd_en_i` is 0.
- R3: While `phi0_sync_i` is 1 and the current phase position is at or above CUTOFF = HALF_CYCLE − SYNC_DELAY + DRIVE_MARGIN (22 with defaults), `bus_oe_n_o` is 1 whatever the card requests.
- R4: The phase position is 0 in the first clock cycle in which `phi0_sync_i` differs from its value at the previous clock edge. It then rises by one per clock edge. Every change of `phi0_sync_i` restarts it from 0.
- R5: While `phi0_sync_i` is 0, the cutoff has no effect at any phase position, including a saturated one.
- R6: `bus_oe_n_o` follows changes of `card_rd_en_i` within the same clock cycle, with no clock edge in between.
- R7: While `rst_ni` is 0, `bus_oe_n_o` is 1. Reset clears the phase position to 0 and clears the remembered phi0 level to 0.
- R8: The 6-bit phase position saturates at 63 and does not wrap. A phi0-high phase longer than 63 cycles therefore keeps the drive cut off until phi0 changes.
- R9: With DRIVE_ENABLE = 0, `bus_oe_n_o` is 1 at all times.
- R10: The cutoff follows its parameters. A parameter set whose cutoff is below 1 or not below HALF_CYCLE, or whose HALF_CYCLE does not fit the counter, is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast logic clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| phi0_sync_i | input | 1 | Bus phase after the synchronizer (1 = data phase) |
| card_rd_en_i | input | NUM_CARDS | Read-enable from each emulated card |
| bus_oe_n_o | output | 1 | Bridge data-drive enable, active low |

## Verification
The bench builds three copies of the block and drives them with the same stimulus.
- The default copy (cutoff 22) covers the normal 26-cycle phase and its cutoff boundary.
- A copy with HALF_CYCLE 20, SYNC_DELAY 4 and DRIVE_MARGIN 1 moves the cutoff to 17. This shows that the cutoff tracks its parameters and that the gate is not tied to a hard-wired position.
- A copy with DRIVE_ENABLE = 0 shows that the global enable masks every request.

Random phase lengths of up to 70 cycles push the counter into saturation in both phases. Directed steps cover reset, same-cycle changes of the request, and single-cycle phase toggles.

// File: rtl/bdg_pkg.sv
package bdg_pkg;

    // Default widths and timing, in logic-clock cycles.
    localparam int DEF_PHASE_W    = 6;
    localparam int DEF_HALF_CYCLE = 26;
    localparam int DEF_SYNC_DELAY = 6;
    localparam int DEF_MARGIN     = 2;
    localparam int DEF_NUM_CARDS  = 5;

    // Phase position at which bus drive is withdrawn.
    function automatic int cutoff_pos(input int half_cycle, input int sync_delay,
                                      input int margin);
        return half_cycle - sync_delay + margin;
    endfunction

endpackage

// File: rtl/bdg_phase_track.sv
module bdg_phase_track #(
    parameter int PHASE_W = bdg_pkg::DEF_PHASE_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               phi0_i,
    output logic [PHASE_W-1:0] phase_o
);

    localparam logic [PHASE_W-1:0] CNT_MAX = {PHASE_W{1'b1}};
    localparam logic [PHASE_W-1:0] CNT_ONE = PHASE_W'(1);

    typedef struct packed {
        logic               prev;
        logic [PHASE_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic phase_edge;

    assign phase_edge = phi0_i ^ trk_q.prev;

    always_comb begin
        trk_d      = trk_q;
        trk_d.prev = phi0_i;
        if (phase_edge) begin
            trk_d.cnt = CNT_ONE;
        end else if (trk_q.cnt != CNT_MAX) begin
            trk_d.cnt = trk_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // The edge cycle itself is position 0; later cycles read the register.
    assign phase_o = phase_edge ? '0 : trk_q.cnt;

    // R4
    restart_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phi0_i != trk_q.prev) |=> (trk_q.cnt == CNT_ONE));

    // R8
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trk_q.cnt == CNT_MAX && phi0_i == trk_q.prev) |=> (trk_q.cnt == CNT_MAX));

    // R7
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (trk_q.cnt == '0 && !trk_q.prev));

endmodule

// File: rtl/bdg_req_merge.sv
module bdg_req_merge #(
    parameter int NUM_CARDS    = bdg_pkg::DEF_NUM_CARDS,
    parameter bit DRIVE_ENABLE = 1'b1
) (
    input  logic [NUM_CARDS-1:0] rd_en_i,
    output logic                 req_o
);

    assign req_o = DRIVE_ENABLE && (|rd_en_i);

    // R9
    always_comb begin
        if (!DRIVE_ENABLE) begin
            global_mask_chk: assert (!req_o);
        end
    end

endmodule

// File: rtl/bdg_cut_gate.sv
module bdg_cut_gate #(
    parameter int PHASE_W = bdg_pkg::DEF_PHASE_W,
    parameter int CUTOFF  = 22
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               phi0_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               req_i,
    output logic               oe_n_o
);

    localparam logic [PHASE_W-1:0] CUT_V = PHASE_W'(CUTOFF);

    logic cut_hit;

    assign cut_hit = phi0_i && (phase_i >= CUT_V);
    assign oe_n_o  = !(rst_ni && req_i && !cut_hit);

    // R3
    late_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phi0_i && phase_i >= CUT_V) |-> oe_n_o);

    // R5
    phi1_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!phi0_i && req_i) |-> !oe_n_o);

    // R7
    reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> oe_n_o);

endmodule

// File: rtl/bus_drive_gate.sv
module bus_drive_gate #(
    parameter int NUM_CARDS    = bdg_pkg::DEF_NUM_CARDS,
    parameter int PHASE_W      = bdg_pkg::DEF_PHASE_W,
    parameter int HALF_CYCLE   = bdg_pkg::DEF_HALF_CYCLE,
    parameter int SYNC_DELAY   = bdg_pkg::DEF_SYNC_DELAY,
    parameter int DRIVE_MARGIN = bdg_pkg::DEF_MARGIN,
    parameter bit DRIVE_ENABLE = 1'b1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 phi0_sync_i,
    input  logic [NUM_CARDS-1:0] card_rd_en_i,
    output logic                 bus_oe_n_o
);

    localparam int CUTOFF = bdg_pkg::cutoff_pos(HALF_CYCLE, SYNC_DELAY, DRIVE_MARGIN);

    // R10: reject cutoffs outside the half-cycle and half-cycles the counter cannot hold
    if (CUTOFF < 1 || CUTOFF >= HALF_CYCLE) begin : g_bad_cutoff
        $error("bus_drive_gate: cutoff %0d outside half-cycle %0d", CUTOFF, HALF_CYCLE);
    end
    if (HALF_CYCLE > (2 ** PHASE_W) - 1) begin : g_bad_width
        $error("bus_drive_gate: half-cycle %0d exceeds counter range", HALF_CYCLE);
    end

    logic [PHASE_W-1:0] phase;
    logic               drive_req;

    bdg_phase_track #(
        .PHASE_W (PHASE_W)
    ) u_track (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phi0_i  (phi0_sync_i),
        .phase_o (phase)
    );

    bdg_req_merge #(
        .NUM_CARDS    (NUM_CARDS),
        .DRIVE_ENABLE (DRIVE_ENABLE)
    ) u_merge (
        .rd_en_i (card_rd_en_i),
        .req_o   (drive_req)
    );

    bdg_cut_gate #(
        .PHASE_W (PHASE_W),
        .CUTOFF  (CUTOFF)
    ) u_gate (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phi0_i  (phi0_sync_i),
        .phase_i (phase),
        .req_i   (drive_req),
        .oe_n_o  (bus_oe_n_o)
    );

    // R2
    idle_bus_chk: assert property (@(posedge clk_i)
        (card_rd_en_i == '0) |-> bus_oe_n_o);

endmodule

// File: tb/bus_drive_gate_test.sv
module bus_drive_gate_test;

    localparam int NC      = 5;
    localparam int CUT_DEF = 22;
    localparam int CUT_ALT = 17;
    localparam int SAT     = 63;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          phi0;
    logic [NC-1:0] rd;
    logic          oe_def, oe_alt, oe_off;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model of the phase position, kept from the requirement text (R4, R7, R8).
    int   m_cnt  = 0;
    logic m_prev = 1'b0;
    int   cur_ph = 0;

    always #5 clk = ~clk;

    bus_drive_gate uut (
        .clk_i (clk), .rst_ni (rst_n), .phi0_sync_i (phi0),
        .card_rd_en_i (rd), .bus_oe_n_o (oe_def)
    );

    bus_drive_gate #(.HALF_CYCLE(20), .SYNC_DELAY(4), .DRIVE_MARGIN(1)) uut_alt (
        .clk_i (clk), .rst_ni (rst_n), .phi0_sync_i (phi0),
        .card_rd_en_i (rd), .bus_oe_n_o (oe_alt)
    );

    bus_drive_gate #(.DRIVE_ENABLE(1'b0)) uut_off (
        .clk_i (clk), .rst_ni (rst_n), .phi0_sync_i (phi0),
        .card_rd_en_i (rd), .bus_oe_n_o (oe_off)
    );

    function automatic logic exp_oe(int cut, bit en, logic rs, logic p, int ph,
                                    logic [NC-1:0] r);
        if (!rs || !en || r == '0) return 1'b1;
        if (p && ph >= cut) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string tag_of(int cut, bit en, logic rs, logic p, int ph,
                                     logic [NC-1:0] r);
        if (!rs) return "R7";
        if (!en) return "R9";
        if (r == '0) return "R2";
        if (p && ph >= SAT) return "R8";
        if (p && (ph == cut || ph == cut - 1)) return (cut == CUT_ALT) ? "R10" : "R4";
        if (p && ph >= cut) return "R3";
        if (!p) return "R5";
        return "R1";
    endfunction

    task automatic check(string who, string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s %s phase=%0d: actual %b expected %b",
                     tag, who, cur_ph, act, exp);
        end
    endtask

    task automatic check_all();
        logic e;
        e = exp_oe(CUT_DEF, 1'b1, rst_n, phi0, cur_ph, rd);
        check("uut", tag_of(CUT_DEF, 1'b1, rst_n, phi0, cur_ph, rd), oe_def, e);
        e = exp_oe(CUT_ALT, 1'b1, rst_n, phi0, cur_ph, rd);
        check("uut_alt", tag_of(CUT_ALT, 1'b1, rst_n, phi0, cur_ph, rd), oe_alt, e);
        e = exp_oe(CUT_DEF, 1'b0, rst_n, phi0, cur_ph, rd);
        check("uut_off", "R9", oe_off, e);
    endtask

    // Drive at the falling edge, check 1 ns later, advance the model at the rising edge.
    task automatic step(logic p, logic [NC-1:0] r, logic rs);
        @(negedge clk);
        phi0  = p;
        rd    = r;
        rst_n = rs;
        cur_ph = (rs && p != m_prev) ? 0 : m_cnt;
        #1;
        check_all();
        @(posedge clk);
        if (!rs) begin
            m_cnt  = 0;
            m_prev = 1'b0;
        end else begin
            m_cnt  = (p != m_prev) ? 1 : ((m_cnt < SAT) ? m_cnt + 1 : SAT);
            m_prev = p;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("[TB] FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        logic p;
        phi0  = 1'b0;
        rd    = '0;
        rst_n = 1'b0;
        seed  = $urandom(32'd4711);

        // R7: reset holds drive off even with requests and phi0 high
        step(1'b0, 5'b11111, 1'b0);
        step(1'b1, 5'b00001, 1'b0);
        step(1'b0, 5'b00100, 1'b0);

        // R1/R5: after reset, phi1 with a request drives
        step(1'b0, 5'b00010, 1'b1);
        step(1'b0, 5'b00010, 1'b1);

        // R6: same-cycle response to request changes, no clock edge between
        @(negedge clk);
        rd = 5'b00000;
        #1; cur_ph = m_cnt;
        check("uut", "R6", oe_def, 1'b1);
        rd = 5'b10000;
        #1;
        check("uut", "R6", oe_def, 1'b0);
        rd = 5'b00000;
        #1;
        check("uut", "R6", oe_def, 1'b1);
        @(posedge clk);
        m_cnt = (m_cnt < SAT) ? m_cnt + 1 : SAT;

        // R4/R3: a nominal 26-cycle phi0-high phase with a constant request
        for (int i = 0; i < 26; i++) step(1'b1, 5'b01000, 1'b1);
        // R5: long phi1 reaching saturation, the cutoff must not apply
        for (int i = 0; i < 75; i++) step(1'b0, 5'b00001, 1'b1);
        // R8: long phi0-high phase, stays cut off after saturation
        for (int i = 0; i < 75; i++) step(1'b1, 5'b00001, 1'b1);
        // R4: single-cycle toggles restart the phase each time
        for (int i = 0; i < 6; i++) step(i[0], 5'b11000, 1'b1);

        // Random phases: mostly nominal length, some short or beyond saturation
        p = 1'b0;
        for (int h = 0; h < 80; h++) begin
            int len;
            p   = ~p;
            len = ($urandom % 4 == 0) ? 1 + int'($urandom_range(0, 69)) : 26;
            for (int c = 0; c < len; c++) begin
                logic [NC-1:0] r;
                r = ($urandom % 3 == 0) ? '0 : NC'($urandom);
                step(p, r, 1'b1);
            end
        end

        // R7: reset in the middle of phi0 high returns drive to off
        step(1'b1, 5'b00011, 1'b0);
        step(1'b0, 5'b00011, 1'b1);
        step(1'b1, 5'b00011, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule